// File: doc/BRIEF.md
# Companion-chip control registers with general-purpose I/O

This block sits on a simple synchronous register bus. Each cycle the bus can carry an address, a write strobe with write data, and a read strobe. The block holds 16-bit configuration storage: a mode word, a clock divider, a clock control word, three interrupt bookkeeping words, a power word and a fixed status word. It also holds a 16-line general-purpose I/O bank made of a direction register and a level register.

Output lines present the level bits that are configured as outputs. They are held in a registered copy that changes only on a direction or level write. External input lines overwrite level bits directly whenever they change. Read data is registered. Any access to an offset with no register behind it returns zero and raises a one-cycle error flag.

Top module: `cmp_ctl_gpio`

## Requirements
- R1: Only the low 6 address bits select a register. The higher bits are ignored. Offsets: 0x00 mode, 0x04 clock divider, 0x08 status, 0x0C power, 0x10 clock control, 0x14 interrupt request, 0x18 interrupt mask, 0x1C interrupt status, 0x20 direction, 0x24 level (write port), 0x28 level (read port).
- R2: Only bits 15:0 of the write data are stored. Higher bits are discarded.
- R3: A power write stores the written value. When bit 7 of that value is 1, bits 15 and 6 are also stored as 1 (written 0x0080 reads back 0x80C0).
- R4: The status word reads 0x0002 at all times. Writes to offset 0x08 change nothing and do not raise the error flag.
- R5: A write to offset 0x24 or 0x28 stores the write data ANDed with the current direction register. A read of either offset returns the level register.
- R6: gpio_out equals level AND direction as computed at the clock edge of each direction or level write, and is visible in the cycle after it. gpio_out holds in every other cycle.
- R7: A gpio_in bit that differs from its value in the previous cycle copies its new value into the level bit at the next edge, whatever the direction bit is. Such a change leaves gpio_out untouched. If it falls in the same cycle as a level write, the input wins for that bit.
- R8: Mode, clock divider, clock control, interrupt request, interrupt mask and interrupt status each read back the last value written.
- R9: A read of any other offset returns 0, and a write to one changes no register. In both cases bad_access is 1 for exactly the following cycle. Accesses to defined offsets leave it 0.
- R10: After reset, every register reads 0 except status (0x0002), gpio_out is 0 and bad_access is 0.
- R11: bus_rdata presents the addressed value in the cycle after bus_rd_en. It shows the value from before any write in that same cycle, and holds when no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Register address; low 6 bits decoded |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data; low 16 bits used |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| bad_access | output | 1 | One-cycle flag for an access to an undefined offset |
| gpio_in | input | GPIO_N | External input lines |
| gpio_out | output | GPIO_N | Registered masked output lines |

## Verification
The bench goes after the stale-output window. Input changes move level bits while gpio_out keeps the old masked value until the next direction or level write. A design that tracked level combinationally would show the new input on gpio_out too early.

It also checks the collision of a level write with an input change in the same cycle. A wrong priority would lose the input bit.

Other checks cover the power write with bit 7, which must add bits 15 and 6, and aliased level offsets reached through addresses with high bits set. A design that decoded the full address, or treated 0x28 as read-only, would read back the wrong level.

Undefined offsets must return zero with a single-cycle flag, and status writes must be silent. A design that stored into the status word or held the flag would fail those checks.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int REG_W      = 16;
    localparam int DEC_W      = 6;
    localparam int N_STORE    = 6;
    localparam int IDX_W      = $clog2(N_STORE);

    localparam logic [DEC_W-1:0] OFS_MODE = 6'h00;
    localparam logic [DEC_W-1:0] OFS_CDIV = 6'h04;
    localparam logic [DEC_W-1:0] OFS_STAT = 6'h08;
    localparam logic [DEC_W-1:0] OFS_PWR  = 6'h0C;
    localparam logic [DEC_W-1:0] OFS_CCTL = 6'h10;
    localparam logic [DEC_W-1:0] OFS_IREQ = 6'h14;
    localparam logic [DEC_W-1:0] OFS_IMSK = 6'h18;
    localparam logic [DEC_W-1:0] OFS_ISTS = 6'h1C;
    localparam logic [DEC_W-1:0] OFS_DIR  = 6'h20;
    localparam logic [DEC_W-1:0] OFS_LVLW = 6'h24;
    localparam logic [DEC_W-1:0] OFS_LVLR = 6'h28;

    localparam int               PWR_TRIG_BIT = 7;
    localparam logic [REG_W-1:0] PWR_FORCE    = 16'h8040;
    localparam logic [REG_W-1:0] STATUS_VAL   = 16'h0002;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STORE,
        SEL_STAT,
        SEL_PWR,
        SEL_DIR,
        SEL_LVL
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } dec_t;
endpackage

// File: rtl/cmp_addr_dec.sv
module cmp_addr_dec
    import cmp_pkg::*;
(
    input  logic [DEC_W-1:0] ofs,
    output dec_t             dec
);
    always_comb begin
        dec.sel = SEL_NONE;
        dec.idx = '0;
        case (ofs)
            OFS_MODE: begin dec.sel = SEL_STORE; dec.idx = IDX_W'(0); end
            OFS_CDIV: begin dec.sel = SEL_STORE; dec.idx = IDX_W'(1); end
            OFS_CCTL: begin dec.sel = SEL_STORE; dec.idx = IDX_W'(2); end
            OFS_IREQ: begin dec.sel = SEL_STORE; dec.idx = IDX_W'(3); end
            OFS_IMSK: begin dec.sel = SEL_STORE; dec.idx = IDX_W'(4); end
            OFS_ISTS: begin dec.sel = SEL_STORE; dec.idx = IDX_W'(5); end
            OFS_STAT: dec.sel = SEL_STAT;
            OFS_PWR:  dec.sel = SEL_PWR;
            OFS_DIR:  dec.sel = SEL_DIR;
            OFS_LVLW,
            OFS_LVLR: dec.sel = SEL_LVL;
            default:  dec.sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/cmp_regfile.sv
module cmp_regfile
    import cmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  dec_t             dec,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rd_val
);
    typedef struct packed {
        logic [N_STORE-1:0][REG_W-1:0] store;
        logic [REG_W-1:0]              pwr;
    } rf_t;

    rf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (dec.sel)
                SEL_STORE: st_d.store[dec.idx] = wdata;
                SEL_PWR:   st_d.pwr = wdata | (wdata[PWR_TRIG_BIT] ? PWR_FORCE : '0);
                default:   ;
            endcase
        end
        case (dec.sel)
            SEL_STORE: rd_val = st_q.store[dec.idx];
            SEL_STAT:  rd_val = STATUS_VAL;
            SEL_PWR:   rd_val = st_q.pwr;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PWR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.sel == SEL_PWR && wdata[PWR_TRIG_BIT])
        |=> ((st_q.pwr & PWR_FORCE) == PWR_FORCE)) else $error("power force bits"); // R3

    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && dec.sel == SEL_PWR) |=> $stable(st_q.pwr)) else $error("power changed without write"); // R9
endmodule

// File: rtl/cmp_gpio_bank.sv
module cmp_gpio_bank #(
    parameter int GPIO_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_wr,
    input  logic              lvl_wr,
    input  logic [GPIO_N-1:0] wdata,
    input  logic [GPIO_N-1:0] gpio_in,
    output logic [GPIO_N-1:0] dir_val,
    output logic [GPIO_N-1:0] lvl_val,
    output logic [GPIO_N-1:0] gpio_out
);
    typedef struct packed {
        logic [GPIO_N-1:0] dir;
        logic [GPIO_N-1:0] lvl;
        logic [GPIO_N-1:0] out;
        logic [GPIO_N-1:0] in_prev;
    } gb_t;

    gb_t               st_d, st_q;
    logic [GPIO_N-1:0] in_chg;

    always_comb begin
        st_d         = st_q;
        st_d.in_prev = gpio_in;
        in_chg       = gpio_in ^ st_q.in_prev;
        if (dir_wr) st_d.dir = wdata;
        if (lvl_wr) st_d.lvl = wdata & st_q.dir;
        st_d.lvl = (st_d.lvl & ~in_chg) | (gpio_in & in_chg);
        if (dir_wr || lvl_wr) st_d.out = st_d.lvl & st_d.dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_val  = st_q.dir;
    assign lvl_val  = st_q.lvl;
    assign gpio_out = st_q.out;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(dir_wr || lvl_wr) |=> $stable(gpio_out)) else $error("output moved without write"); // R6

    AST_OUT_IN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (gpio_out & ~st_q.dir) == '0) else $error("output outside direction"); // R6

    AST_LVL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_wr && in_chg == '0) |=> ((st_q.lvl & ~$past(st_q.dir)) == '0)) else $error("level not masked"); // R5

    AST_IN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_chg != '0) |=> ((st_q.lvl & $past(in_chg)) == ($past(gpio_in) & $past(in_chg)))) else $error("input not taken"); // R7
endmodule

// File: rtl/cmp_ctl_gpio.sv
module cmp_ctl_gpio
    import cmp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32,
    parameter int GPIO_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_rd_en,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bad_access,
    input  logic [GPIO_N-1:0] gpio_in,
    output logic [GPIO_N-1:0] gpio_out
);
    typedef struct packed {
        logic [REG_W-1:0] rdata;
        logic             bad;
    } top_t;

    top_t              st_d, st_q;
    dec_t              dec;
    logic [REG_W-1:0]  wdata16;
    logic [REG_W-1:0]  rf_val;
    logic [GPIO_N-1:0] dir_val, lvl_val;
    logic              hit, dir_wr, lvl_wr;
    logic [REG_W-1:0]  rd_mux;
    logic              unused_hi;

    assign wdata16   = bus_wdata[REG_W-1:0];
    assign unused_hi = ^{bus_addr[ADDR_W-1:DEC_W], bus_wdata[BUS_W-1:REG_W]};

    cmp_addr_dec u_dec (
        .ofs (bus_addr[DEC_W-1:0]),
        .dec (dec)
    );

    cmp_regfile u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr_en),
        .dec    (dec),
        .wdata  (wdata16),
        .rd_val (rf_val)
    );

    cmp_gpio_bank #(.GPIO_N(GPIO_N)) u_gpio (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_wr   (dir_wr),
        .lvl_wr   (lvl_wr),
        .wdata    (wdata16[GPIO_N-1:0]),
        .gpio_in  (gpio_in),
        .dir_val  (dir_val),
        .lvl_val  (lvl_val),
        .gpio_out (gpio_out)
    );

    always_comb begin
        hit    = (dec.sel != SEL_NONE);
        dir_wr = bus_wr_en && (dec.sel == SEL_DIR);
        lvl_wr = bus_wr_en && (dec.sel == SEL_LVL);
        rd_mux = rf_val;
        if (dec.sel == SEL_DIR) begin
            rd_mux = '0;
            rd_mux[GPIO_N-1:0] = dir_val;
        end else if (dec.sel == SEL_LVL) begin
            rd_mux = '0;
            rd_mux[GPIO_N-1:0] = lvl_val;
        end
        st_d       = st_q;
        st_d.bad   = (bus_rd_en || bus_wr_en) && !hit;
        if (bus_rd_en) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bad_access = st_q.bad;

    AST_STAT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr[DEC_W-1:0] == OFS_STAT) |=> (bus_rdata == STATUS_VAL)) else $error("status read"); // R4

    AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bad_access == 1'b0 && !hit) |=> (bus_rdata == '0 && bad_access)) else $error("bad read not zero"); // R9

    AST_BAD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd_en || bus_wr_en) |=> !bad_access) else $error("bad flag stuck"); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata)) else $error("rdata moved without read"); // R11
endmodule

// File: tb/tb_cmp_ctl_gpio.sv
`timescale 1ns/1ps
module tb_cmp_ctl_gpio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [15:0] bus_rdata;
    logic        bad_access;
    logic [15:0] gpio_in = '0;
    logic [15:0] gpio_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic rd_seen = 1'b0;

    logic [15:0] exp_q[$];
    logic        bad_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cmp_ctl_gpio dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .bad_access(bad_access), .gpio_in(gpio_in), .gpio_out(gpio_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= bus_rd_en;

    // monitor: pops scoreboard items the cycle after each read
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R11 actual=unexpected read expected=none");
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic logic        b = bad_q.pop_front();
                automatic string       t = tag_q.pop_front();
                check({t, " rdata"}, {16'h0, bus_rdata}, {16'h0, e});
                check({t, " bad"}, {31'h0, bad_access}, {31'h0, b});
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] e, input logic b, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        exp_q.push_back(e); bad_q.push_back(b); tag_q.push_back(t);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 gpio_out", {16'h0, gpio_out}, 32'h0);
        check("R10 bad", {31'h0, bad_access}, 32'h0);
        rd(12'h000, 16'h0000, 1'b0, "R10 mode");
        rd(12'h008, 16'h0002, 1'b0, "R10 status");
        rd(12'h020, 16'h0000, 1'b0, "R10 dir");
        rd(12'h00C, 16'h0000, 1'b0, "R10 power");

        // R8 plain storage, R1 upper address bits ignored
        wr(12'h000, 32'h1111);
        wr(12'hF04, 32'h2222);
        wr(12'h510, 32'h3333);
        wr(12'h014, 32'h4444);
        wr(12'h018, 32'h5555);
        wr(12'hA1C, 32'h6666);
        rd(12'h040, 16'h1111, 1'b0, "R8 R1 mode");
        rd(12'h004, 16'h2222, 1'b0, "R8 cdiv");
        rd(12'h010, 16'h3333, 1'b0, "R8 cctl");
        rd(12'hC14, 16'h4444, 1'b0, "R8 R1 ireq");
        rd(12'h018, 16'h5555, 1'b0, "R8 imsk");
        rd(12'h01C, 16'h6666, 1'b0, "R8 ists");

        // R2 upper data bits dropped
        wr(12'h000, 32'hABCD_1234);
        rd(12'h000, 16'h1234, 1'b0, "R2 mode");

        // R3 power side effect
        wr(12'h00C, 32'h0080);
        rd(12'h00C, 16'h80C0, 1'b0, "R3 pwr 0080");
        wr(12'h00C, 32'h0003);
        rd(12'h00C, 16'h0003, 1'b0, "R3 pwr 0003");
        wr(12'h00C, 32'h0180);
        rd(12'h00C, 16'h81C0, 1'b0, "R3 pwr 0180");

        // R4 status write ignored, not flagged
        wr(12'h008, 32'hFFFF);
        check("R4 status write flag", {31'h0, bad_access}, 32'h0);
        rd(12'h008, 16'h0002, 1'b0, "R4 status");

        // R11 read sees pre-write value in a same-cycle write
        @(negedge clk);
        bus_addr = 12'h004; bus_wdata = 32'h9999; bus_wr_en = 1'b1; bus_rd_en = 1'b1;
        exp_q.push_back(16'h2222); bad_q.push_back(1'b0); tag_q.push_back("R11 old value");
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b0;
        @(negedge clk);
        check("R11 rdata hold", {16'h0, bus_rdata}, 32'h2222);
        rd(12'h004, 16'h9999, 1'b0, "R11 new value");

        // R9 undefined offsets
        rd(12'h02C, 16'h0000, 1'b1, "R9 read 2C");
        rd(12'h001, 16'h0000, 1'b1, "R9 read 01");
        wr(12'h030, 32'h7777);
        check("R9 write flag", {31'h0, bad_access}, 32'h1);
        @(negedge clk);
        check("R9 flag one cycle", {31'h0, bad_access}, 32'h0);
        rd(12'h000, 16'h1234, 1'b0, "R9 mode untouched");

        // R5 / R6 direction and level
        wr(12'h020, 32'h00FF);
        check("R6 out after dir", {16'h0, gpio_out}, 32'h0000);
        wr(12'h024, 32'hFFFF);
        check("R6 out after lvl", {16'h0, gpio_out}, 32'h00FF);
        rd(12'h028, 16'h00FF, 1'b0, "R5 lvl masked");
        wr(12'h328, 32'h0F0F);
        check("R5 R6 out via 28", {16'h0, gpio_out}, 32'h000F);
        rd(12'h024, 16'h000F, 1'b0, "R5 alias read");

        // R7 input lines, outputs stale until next write
        @(negedge clk); gpio_in = 16'h1001;
        @(negedge clk);
        rd(12'h028, 16'h100F, 1'b0, "R7 input sets bit12");
        check("R7 out stale", {16'h0, gpio_out}, 32'h000F);
        @(negedge clk); gpio_in = 16'h1000;
        @(negedge clk);
        rd(12'h028, 16'h100E, 1'b0, "R7 input clears bit0");
        check("R7 out stale 2", {16'h0, gpio_out}, 32'h000F);
        wr(12'h020, 32'hF0FF);
        check("R6 out refresh", {16'h0, gpio_out}, 32'h100E);
        wr(12'h020, 32'h0000);
        check("R6 out dir zero", {16'h0, gpio_out}, 32'h0000);
        rd(12'h024, 16'h100E, 1'b0, "R6 lvl kept");

        // R7 collision: level write and input change same cycle
        wr(12'h020, 32'hFFFF);
        check("R6 out full dir", {16'h0, gpio_out}, 32'h100E);
        @(negedge clk);
        bus_addr = 12'h024; bus_wdata = 32'h0000; bus_wr_en = 1'b1; gpio_in = 16'h1008;
        @(negedge clk);
        bus_wr_en = 1'b0;
        check("R7 collision out", {16'h0, gpio_out}, 32'h0008);
        rd(12'h028, 16'h0008, 1'b0, "R7 collision lvl");

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule